// File: doc/BRIEF.md
# Programmable Baud Clock Generator

This block turns one master clock into a square wave at sixteen times a chosen serial bit rate, for the transmit and receive sides of an asynchronous serial port. A four-bit rate code picks one of thirteen divided rates or one of two pass-through inputs. One pass-through carries a user frequency and the other a static level, which gives a zero-baud output. The master tick comes either from every edge of the block clock (crystal mode) or from rising edges of an external clock pin (external mode). The nominal master rate is 2.4576 MHz. A slower master scales every output down in proportion, with no correction.

A three-bit prescaler runs on every master tick and its bits are brought out. Outside logic can then derive extra channels from one generator. A strobe marks each master tick. An initialization state machine has three states: XTAL, ARMED and RUN. It starts in XTAL. XTAL goes to ARMED when the crystal select drops. ARMED goes to RUN when the external clock is first seen high. That same transition fires a single scan reset. Any state returns to XTAL when the crystal select is high. In XTAL, a high external clock holds all counters in reset.

Top module: `bcg_baud_gen`

## Requirements
- R1: While rst_n is low, baud_out is 0 and tap_q is 0.
- R2: In crystal mode (xtal_sel=1, ext_clk=0), master_strobe is 1 on every cycle and tap_q increments by one modulo 8 on every clock.
- R3: In crystal mode, rate codes 0 to 12 give baud_out high and low phases of exactly H master ticks each. H is round(76800/rate) for these rates: 50, 75, 110, 134.5, 150, 300, 600, 1200, (code 8, see R4), 2400, 4800, 9600, 200 baud. The H values are 1536, 1024, 698, 571, 512, 256, 128, 64, -, 32, 16, 8, 384.
- R4: Code 8 (1800 baud) alternates half-periods of 43 and 42 ticks, so that one high phase plus one low phase equals 85 ticks.
- R5: Code 13 gives the same 2400 baud output as code 9 (H = 32).
- R6: Code 14 copies user_freq to baud_out one clock later; user_level has no effect.
- R7: Code 15 copies user_level to baud_out one clock later.
- R8: In crystal mode, ext_clk high asserts scan_rst and holds tap_q and baud_out at 0.
- R9: After xtal_sel falls, the first cycle with ext_clk high raises scan_rst for exactly one cycle. Later ext_clk highs do not raise it again until crystal mode is re-entered.
- R10: In external mode after that pulse, tap_q and the rate divider advance only on rising edges of ext_clk, counted from zero. With code 11, baud_out rises on the 8th rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one master tick per edge in crystal mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_sel | input | 1 | 1 = crystal mode, 0 = external clock mode |
| ext_clk | input | 1 | External master clock, synchronous to clk |
| rate_sel | input | 4 | Rate code |
| user_freq | input | 1 | User frequency routed by code 14 |
| user_level | input | 1 | Static level routed by code 15 |
| baud_out | output | 1 | Registered 16x bit-rate clock |
| master_strobe | output | 1 | High on each counted master tick |
| tap_q | output | 3 | Prescaler bits for extra channels |
| scan_rst | output | 1 | Counter clear (differentiator pulse or held reset) |

## Verification
A wrong half-period count or a wrong table entry shows up as a wrong high or low width on baud_out. The error appears within one output period of the affected code, and the sweep checks every code. A state machine stuck in ARMED or re-arming in RUN shows up as a missing or repeated scan_rst within a few external clock edges. A wrong tick source shows up as tap_q moving without an ext_clk rising edge. A wrong pass-through mux shows up one clock after the user input changes.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    typedef enum logic [1:0] {
        ST_XTAL,
        ST_ARMED,
        ST_RUN
    } init_st_e;

    // Twice the bit rate (so 134.5 baud stays integral) for each rate code.
    function automatic int unsigned rate_x2(input int unsigned code);
        case (code)
            0:       return 100;
            1:       return 150;
            2:       return 220;
            3:       return 269;
            4:       return 300;
            5:       return 600;
            6:       return 1200;
            7:       return 2400;
            8:       return 3600;
            9:       return 4800;
            10:      return 9600;
            11:      return 19200;
            12:      return 400;
            13:      return 4800;
            default: return 19200;
        endcase
    endfunction

    // Master ticks per half output period: master / (32 * rate), rounded.
    function automatic int unsigned half_ticks(input int unsigned master_hz,
                                               input int unsigned code);
        int unsigned num;
        int unsigned den;
        num = master_hz / 16;
        den = rate_x2(code);
        return (num + den / 2) / den;
    endfunction

    // Same ratio truncated; used as the short half for the alternating rate.
    function automatic int unsigned half_ticks_floor(input int unsigned master_hz,
                                                     input int unsigned code);
        return (master_hz / 16) / rate_x2(code);
    endfunction

endpackage

// File: rtl/bcg_init_fsm.sv
module bcg_init_fsm
    import bcg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_sel,
    input  logic ext_clk,
    output logic init_pulse,
    output logic ext_running
);

    init_st_e state_q;
    init_st_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_XTAL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        init_pulse  = 1'b0;
        ext_running = 1'b0;
        unique case (state_q)
            ST_XTAL: begin
                if (!xtal_sel) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (xtal_sel) begin
                    state_d = ST_XTAL;
                end else if (ext_clk) begin
                    init_pulse = 1'b1;
                    state_d    = ST_RUN;
                end
            end
            ST_RUN: begin
                ext_running = 1'b1;
                if (xtal_sel) state_d = ST_XTAL;
            end
            default: state_d = ST_XTAL;
        endcase
    end

    // R9: the differentiator pulse never lasts two cycles
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> !init_pulse);

    // R9: dropping the crystal select arms the differentiator
    a_r9_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XTAL && !xtal_sel) |=> (state_q == ST_ARMED));

endmodule

// File: rtl/bcg_prescaler.sv
module bcg_prescaler #(
    parameter int unsigned TAP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [TAP_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (clr)  q <= '0;
        else if (tick) q <= q + 1'b1;
    end

    // R8: a clear leaves the taps at zero
    a_r8_clear_taps: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));

    // R2: each tick advances the taps by one
    a_r2_tap_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr) |=> (q == $past(q) + 1'b1));

    // R10: no tick, no movement
    a_r10_tap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(q));

endmodule

// File: rtl/bcg_rate_div.sv
module bcg_rate_div
    import bcg_pkg::*;
#(
    parameter int unsigned MASTER_HZ = 2457600,
    parameter int unsigned SEL_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic             user_freq,
    input  logic             user_level,
    output logic             z
);

    localparam int unsigned NCODE   = 1 << SEL_W;
    localparam int unsigned MAX_H   = half_ticks(MASTER_HZ, 0);
    localparam int unsigned CNT_W   = $clog2(MAX_H + 1);
    localparam int unsigned ALT_SEL = 8;
    localparam int unsigned FREQ_SEL  = NCODE - 2;
    localparam int unsigned LEVEL_SEL = NCODE - 1;

    logic [CNT_W-1:0] half_tbl [NCODE];
    logic [CNT_W-1:0] alt_half;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             phase_q;

    for (genvar g = 0; g < NCODE; g++) begin : g_half
        assign half_tbl[g] = CNT_W'(half_ticks(MASTER_HZ, g));
    end
    assign alt_half = CNT_W'(half_ticks_floor(MASTER_HZ, ALT_SEL));

    always_comb begin
        limit = half_tbl[rate_sel];
        if (rate_sel == SEL_W'(ALT_SEL) && phase_q) limit = alt_half;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
            z       <= 1'b0;
        end else if (clr) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
            z       <= 1'b0;
        end else if (rate_sel == SEL_W'(FREQ_SEL)) begin
            z <= user_freq;
        end else if (rate_sel == SEL_W'(LEVEL_SEL)) begin
            z <= user_level;
        end else if (tick) begin
            if (cnt_q >= limit - 1'b1) begin
                cnt_q   <= '0;
                phase_q <= ~phase_q;
                z       <= ~z;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R7: the level pass-through lands one clock later
    a_r7_level_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && rate_sel == SEL_W'(LEVEL_SEL)) |=> (z == $past(user_level)));

    // R6: the frequency pass-through lands one clock later
    a_r6_freq_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && rate_sel == SEL_W'(FREQ_SEL)) |=> (z == $past(user_freq)));

    // R3: the half-period counter stays inside the longest half-period
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(MAX_H));

    // R8: a clear drops the output
    a_r8_clear_out: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !z);

endmodule

// File: rtl/bcg_baud_gen.sv
module bcg_baud_gen #(
    parameter int unsigned MASTER_HZ = 2457600,
    parameter int unsigned SEL_W     = 4,
    parameter int unsigned TAP_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xtal_sel,
    input  logic             ext_clk,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic             user_freq,
    input  logic             user_level,
    output logic             baud_out,
    output logic             master_strobe,
    output logic [TAP_W-1:0] tap_q,
    output logic             scan_rst
);

    logic ext_d;
    logic ext_rise;
    logic init_pulse;
    logic ext_running;
    logic hold_rst;
    logic clr;
    logic tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_d <= 1'b0;
        else        ext_d <= ext_clk;
    end

    assign ext_rise = ext_clk & ~ext_d;
    assign hold_rst = xtal_sel & ext_clk;
    assign clr      = init_pulse | hold_rst;
    assign tick     = xtal_sel ? 1'b1 : (ext_running & ext_rise);

    assign master_strobe = tick & ~clr;
    assign scan_rst      = clr;

    bcg_init_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .xtal_sel    (xtal_sel),
        .ext_clk     (ext_clk),
        .init_pulse  (init_pulse),
        .ext_running (ext_running)
    );

    bcg_prescaler #(.TAP_W(TAP_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .tick  (tick),
        .q     (tap_q)
    );

    bcg_rate_div #(.MASTER_HZ(MASTER_HZ), .SEL_W(SEL_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .tick       (tick),
        .rate_sel   (rate_sel),
        .user_freq  (user_freq),
        .user_level (user_level),
        .z          (baud_out)
    );

endmodule

// File: tb/bcg_baud_gen_tb.sv
module bcg_baud_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xtal_sel = 1'b1;
    logic       ext_clk = 1'b0;
    logic [3:0] rate_sel = 4'd11;
    logic       user_freq = 1'b0;
    logic       user_level = 1'b0;
    logic       baud_out;
    logic       master_strobe;
    logic [2:0] tap_q;
    logic       scan_rst;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    bcg_baud_gen u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .xtal_sel      (xtal_sel),
        .ext_clk       (ext_clk),
        .rate_sel      (rate_sel),
        .user_freq     (user_freq),
        .user_level    (user_level),
        .baud_out      (baud_out),
        .master_strobe (master_strobe),
        .tap_q         (tap_q),
        .scan_rst      (scan_rst)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wait_level(input logic v);
        while (baud_out !== v) step();
    endtask

    function automatic int exp_half(input int code);
        int r2;
        case (code)
            0: r2 = 100;   1: r2 = 150;   2: r2 = 220;   3: r2 = 269;
            4: r2 = 300;   5: r2 = 600;   6: r2 = 1200;  7: r2 = 2400;
            8: r2 = 3600;  9: r2 = 4800;  10: r2 = 9600; 11: r2 = 19200;
            12: r2 = 400;  default: r2 = 4800;
        endcase
        return (153600 + r2 / 2) / r2;
    endfunction

    task automatic measure(input int code, output int hi, output int lo);
        rate_sel = code[3:0];
        wait_level(1'b1);
        wait_level(1'b0);
        wait_level(1'b1);
        hi = 0;
        while (baud_out === 1'b1) begin hi++; step(); end
        lo = 0;
        while (baud_out === 1'b0) begin lo++; step(); end
    endtask

    initial begin
        int hi;
        int lo;
        int t0;
        int pulses;

        // R1: reset state
        repeat (4) step();
        check(baud_out === 1'b0, "R1 baud_out", baud_out, 0);
        check(tap_q === 3'd0, "R1 tap_q", tap_q, 0);
        rst_n = 1'b1;
        step();

        // R2: crystal mode tap counting and strobe
        for (int i = 0; i < 16; i++) begin
            t0 = tap_q;
            check(master_strobe === 1'b1, "R2 strobe", master_strobe, 1);
            step();
            check(tap_q === 3'((t0 + 1) % 8), "R2 tap step", tap_q, (t0 + 1) % 8);
        end

        // R3, R5: half-period sweep over the divided codes
        for (int c = 0; c < 14; c++) begin
            if (c == 8) continue;
            measure(c, hi, lo);
            check(hi == exp_half(c), (c == 13) ? "R5 high" : "R3 high", hi, exp_half(c));
            check(lo == exp_half(c), (c == 13) ? "R5 low" : "R3 low", lo, exp_half(c));
        end

        // R4: alternating halves for code 8
        measure(8, hi, lo);
        check(hi + lo == 85, "R4 period", hi + lo, 85);
        check((hi == 43 && lo == 42) || (hi == 42 && lo == 43), "R4 halves", hi, 43);

        // R6: frequency pass-through, level ignored
        rate_sel = 4'd14;
        user_level = 1'b1;
        user_freq = 1'b0;
        step(); step();
        check(baud_out === 1'b0, "R6 level ignored", baud_out, 0);
        user_freq = 1'b1;
        step();
        check(baud_out === 1'b1, "R6 freq high", baud_out, 1);
        user_freq = 1'b0;
        step();
        check(baud_out === 1'b0, "R6 freq low", baud_out, 0);

        // R7: level pass-through
        rate_sel = 4'd15;
        user_freq = 1'b1;
        user_level = 1'b1;
        step();
        check(baud_out === 1'b1, "R7 level high", baud_out, 1);
        user_level = 1'b0;
        step();
        check(baud_out === 1'b0, "R7 level low", baud_out, 0);

        // R8: held reset in crystal mode
        rate_sel = 4'd11;
        ext_clk = 1'b1;
        #1;
        check(scan_rst === 1'b1, "R8 scan_rst", scan_rst, 1);
        repeat (20) step();
        check(tap_q === 3'd0, "R8 tap held", tap_q, 0);
        check(baud_out === 1'b0, "R8 baud held", baud_out, 0);
        ext_clk = 1'b0;
        step();

        // R9: single differentiator pulse
        xtal_sel = 1'b0;
        pulses = 0;
        for (int i = 0; i < 3; i++) begin
            #1; if (scan_rst === 1'b1) pulses++;
            step();
        end
        for (int i = 0; i < 8; i++) begin
            ext_clk = 1'b1;
            #1; if (scan_rst === 1'b1) pulses++;
            step();
            ext_clk = 1'b0;
            #1; if (scan_rst === 1'b1) pulses++;
            step();
            // R10: after the pulse edge, i further rises have been counted
            if (i == 5) check(tap_q === 3'd5, "R10 tap count", tap_q, 5);
            if (i == 7) check(baud_out === 1'b0, "R10 before 8th rise", baud_out, 0);
        end
        check(pulses == 1, "R9 pulse count", pulses, 1);

        // R10: idle cycles do not move the taps; 8th rise toggles the output
        t0 = tap_q;
        repeat (5) step();
        check(tap_q === 3'(t0), "R10 idle hold", tap_q, t0);
        ext_clk = 1'b1;
        step();
        check(baud_out === 1'b1, "R10 8th rise", baud_out, 1);
        check(tap_q === 3'd0, "R10 tap wrap", tap_q, 0);
        ext_clk = 1'b0;
        step();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule